// File: doc/BRIEF.md
# Paged Flash Write Sequencer with Read-Back Compare

This block writes a byte range of any start and length into a serial flash that is organised in pages and holds one on-chip page buffer. It cuts the range at page boundaries. For each page it issues at most three commands, each in its own chip-select frame.

- When the page is only partly covered, the first command copies the current page contents into the buffer.
- The second command streams the new bytes into the buffer at their in-page offset and programs the page.
- The third command makes the device compare the buffer against the programmed page.

After every command the block hands control to an external status poller. The poller tells it when the device is ready again, and at the end of the compare it also returns the status byte.

A host starts a transfer with a one-cycle `start` pulse carrying a linear byte address and a length. The payload bytes arrive on a valid/ready stream. Command bytes leave on a byte port with a valid/ready handshake and a chip-select level. When the transfer ends the block pulses `done` and reports three results: the number of bytes committed, a compare failure flag and an out-of-range flag.

The linear address is converted to a page index and an in-page offset. The device address is the page index shifted left by `PAGE_SHIFT` bits, plus the offset.

Top module: `page_write_seq`

## Requirements
- R1: A start with length 0 pulses `done` one cycle after `start`, with `bytes_written` = 0, both error flags low, and no chip-select or poll activity.
- R2: A start whose address plus length exceeds `NUM_PAGES*PAGE_SIZE` pulses `done` one cycle after `start` with `range_err` = 1, `bytes_written` = 0, and no chip-select or poll activity.
- R3: The first chunk is the smaller of the length and the room left in the starting page (`PAGE_SIZE` minus the offset). Each later chunk is the smaller of `PAGE_SIZE` and the bytes still to write.
- R4: For a chunk shorter than `PAGE_SIZE`, the first frame of that page is four bytes: 0x53, then bits [23:16], [15:8] and [7:0] of the page address (page << `PAGE_SHIFT`). It is followed by a poll.
- R5: The program frame is 0x82, then bits [23:16], [15:8] and [7:0] of (page << `PAGE_SHIFT`) + offset, then exactly the chunk's payload bytes in stream order, all in the same frame. It is followed by a poll.
- R6: The compare frame is 0x60 followed by the three page-address bytes, and then a poll. Bit 6 of the returned status set to 1 means mismatch.
- R7: On a mismatch the block pulses `done` with `verify_err` = 1 and sends no further frame. `bytes_written` then counts only the pages that passed before the failing one.
- R8: After a passing compare, `bytes_written` grows by the chunk length, the page index advances and the offset becomes 0. A fully passing transfer ends with `bytes_written` equal to the length and `verify_err` = 0.
- R9: `in_ready` is high only inside a program frame's data phase, while the byte port is accepting. It is low at all other times, including reset.
- R10: `spi_cs` is low whenever `poll_req` is high. Every command therefore occupies its own chip-select frame, and the frame count per page is 2 or 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request, taken when idle |
| start_addr | input | LEN_W | Linear byte address of the first byte |
| length | input | LEN_W | Number of bytes to write |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| bytes_written | output | LEN_W | Bytes committed by passing compares |
| verify_err | output | 1 | Compare mismatch seen, held until next start |
| range_err | output | 1 | Request rejected, held until next start |
| in_valid | input | 1 | Payload byte valid |
| in_data | input | 8 | Payload byte |
| in_ready | output | 1 | Payload byte accepted |
| spi_cs | output | 1 | Chip-select frame, active high |
| spi_tx_valid | output | 1 | Byte offered to the serial port |
| spi_tx_data | output | 8 | Byte to shift out |
| spi_tx_ready | input | 1 | Serial port takes the byte |
| poll_req | output | 1 | Ask the poller to wait for device ready |
| poll_done | input | 1 | Poller reports ready |
| poll_status | input | 8 | Status byte delivered with `poll_done` |

## Verification
The bench sweeps every start address and every legal length of a five-page device whose page size is six bytes. This puts the page-boundary arithmetic under pressure:

- A design with an off-by-one chunk would send a wrong number of data bytes, or skip the preload on an aligned partial tail.
- A design that misjudges a full page would preload when it need not.

Compare failures are injected on the first, middle and last page. A sequencer that ignored bit 6 would keep writing. One that counted the failing chunk would report too many bytes written. Requests of zero length and requests that end one byte past the device must finish in one cycle without any frame; a sloppy range test would start the bus.

// File: rtl/page_write_pkg.sv
package page_write_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LOCATE = 3'd1,
        ST_PLAN   = 3'd2,
        ST_CMD    = 3'd3,
        ST_DATA   = 3'd4,
        ST_POLL   = 3'd5
    } seq_state_e;

    typedef enum logic [1:0] {
        CMD_LOAD = 2'd0,
        CMD_PROG = 2'd1,
        CMD_CMP  = 2'd2
    } flash_cmd_e;

    localparam int CMP_FLAG_BIT = 6;
    localparam int DEV_ADDR_W   = 24;

    function automatic logic [7:0] cmd_opcode(flash_cmd_e c);
        case (c)
            CMD_LOAD: return 8'h53;
            CMD_PROG: return 8'h82;
            default:  return 8'h60;
        endcase
    endfunction

endpackage

// File: rtl/page_chunk_plan.sv
module page_chunk_plan #(
    parameter int PAGE_SIZE = 264,
    parameter int OFS_W     = 9,
    parameter int LEN_W     = 20
) (
    input  logic [OFS_W-1:0] ofs,
    input  logic [LEN_W-1:0] left,
    output logic [OFS_W-1:0] chunk,
    output logic             partial
);
    logic [OFS_W-1:0] room;

    always_comb begin
        room = OFS_W'(PAGE_SIZE) - ofs;
        if (left >= LEN_W'(room)) chunk = room;
        else                      chunk = left[OFS_W-1:0];
        partial = (chunk != OFS_W'(PAGE_SIZE));
    end
endmodule

// File: rtl/page_cmd_bytes.sv
module page_cmd_bytes
    import page_write_pkg::*;
#(
    parameter int PAGE_SHIFT = 9,
    parameter int PG_W       = 12,
    parameter int OFS_W      = 9
) (
    input  flash_cmd_e       cmd,
    input  logic [PG_W-1:0]  page,
    input  logic [OFS_W-1:0] ofs,
    input  logic [1:0]       idx,
    output logic [7:0]       tx_byte
);
    logic [DEV_ADDR_W-1:0] dev_addr;

    always_comb begin
        dev_addr = (DEV_ADDR_W'(page) << PAGE_SHIFT)
                 + ((cmd == CMD_PROG) ? DEV_ADDR_W'(ofs) : '0);
        case (idx)
            2'd0:    tx_byte = cmd_opcode(cmd);
            2'd1:    tx_byte = dev_addr[23:16];
            2'd2:    tx_byte = dev_addr[15:8];
            default: tx_byte = dev_addr[7:0];
        endcase
    end
endmodule

// File: rtl/page_write_seq.sv
module page_write_seq
    import page_write_pkg::*;
#(
    parameter int PAGE_SIZE  = 264,
    parameter int PAGE_SHIFT = 9,
    parameter int NUM_PAGES  = 2048,
    localparam int DEV_BYTES = NUM_PAGES * PAGE_SIZE,
    localparam int LEN_W     = $clog2(DEV_BYTES + 1),
    localparam int PG_W      = $clog2(NUM_PAGES + 1),
    localparam int OFS_W     = $clog2(PAGE_SIZE + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] start_addr,
    input  logic [LEN_W-1:0] length,
    output logic             busy,
    output logic             done,
    output logic [LEN_W-1:0] bytes_written,
    output logic             verify_err,
    output logic             range_err,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    output logic             spi_cs,
    output logic             spi_tx_valid,
    output logic [7:0]       spi_tx_data,
    input  logic             spi_tx_ready,
    output logic             poll_req,
    input  logic             poll_done,
    input  logic [7:0]       poll_status
);
    typedef struct packed {
        seq_state_e       st;
        flash_cmd_e       cmd;
        logic [PG_W-1:0]  page;
        logic [OFS_W-1:0] ofs;
        logic [LEN_W-1:0] scan;
        logic [LEN_W-1:0] left;
        logic [LEN_W-1:0] total;
        logic [LEN_W-1:0] written;
        logic [OFS_W-1:0] chunk;
        logic [OFS_W-1:0] cnt;
        logic [1:0]       idx;
        logic             done;
        logic             verr;
        logic             rerr;
    } seq_t;

    seq_t q, d;

    logic [OFS_W-1:0] plan_chunk;
    logic             plan_partial;
    logic [7:0]       cmd_byte;

    page_chunk_plan #(.PAGE_SIZE(PAGE_SIZE), .OFS_W(OFS_W), .LEN_W(LEN_W)) u_plan (
        .ofs(q.ofs), .left(q.left), .chunk(plan_chunk), .partial(plan_partial)
    );

    page_cmd_bytes #(.PAGE_SHIFT(PAGE_SHIFT), .PG_W(PG_W), .OFS_W(OFS_W)) u_cmd (
        .cmd(q.cmd), .page(q.page), .ofs(q.ofs), .idx(q.idx), .tx_byte(cmd_byte)
    );

    always_comb begin
        d            = q;
        d.done       = 1'b0;
        spi_tx_valid = 1'b0;
        spi_tx_data  = 8'h00;
        in_ready     = 1'b0;
        poll_req     = 1'b0;
        case (q.st)
            ST_IDLE: if (start) begin
                d.verr    = 1'b0;
                d.rerr    = 1'b0;
                d.written = '0;
                d.total   = length;
                if (length == '0) begin
                    d.done = 1'b1;
                end else if (({1'b0, start_addr} + {1'b0, length}) > (LEN_W+1)'(DEV_BYTES)) begin
                    d.done = 1'b1;
                    d.rerr = 1'b1;
                end else begin
                    d.scan = start_addr;
                    d.page = '0;
                    d.left = length;
                    d.st   = ST_LOCATE;
                end
            end
            ST_LOCATE: begin
                if (q.scan >= LEN_W'(PAGE_SIZE)) begin
                    d.scan = q.scan - LEN_W'(PAGE_SIZE);
                    d.page = q.page + 1'b1;
                end else begin
                    d.ofs = q.scan[OFS_W-1:0];
                    d.st  = ST_PLAN;
                end
            end
            ST_PLAN: begin
                d.chunk = plan_chunk;
                d.idx   = '0;
                d.cnt   = '0;
                d.cmd   = plan_partial ? CMD_LOAD : CMD_PROG;
                d.st    = ST_CMD;
            end
            ST_CMD: begin
                spi_tx_valid = 1'b1;
                spi_tx_data  = cmd_byte;
                if (spi_tx_ready) begin
                    d.idx = q.idx + 1'b1;
                    if (q.idx == 2'd3) d.st = (q.cmd == CMD_PROG) ? ST_DATA : ST_POLL;
                end
            end
            ST_DATA: begin
                spi_tx_valid = in_valid;
                spi_tx_data  = in_data;
                in_ready     = spi_tx_ready;
                if (in_valid && spi_tx_ready) begin
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == q.chunk - 1'b1) d.st = ST_POLL;
                end
            end
            ST_POLL: begin
                poll_req = 1'b1;
                if (poll_done) begin
                    d.idx = '0;
                    case (q.cmd)
                        CMD_LOAD: begin d.cmd = CMD_PROG; d.st = ST_CMD; end
                        CMD_PROG: begin d.cmd = CMD_CMP;  d.st = ST_CMD; end
                        default: begin
                            if (poll_status[CMP_FLAG_BIT]) begin
                                d.verr = 1'b1;
                                d.done = 1'b1;
                                d.st   = ST_IDLE;
                            end else begin
                                d.written = q.written + LEN_W'(q.chunk);
                                d.left    = q.left - LEN_W'(q.chunk);
                                d.page    = q.page + 1'b1;
                                d.ofs     = '0;
                                if (q.left == LEN_W'(q.chunk)) begin
                                    d.done = 1'b1;
                                    d.st   = ST_IDLE;
                                end else begin
                                    d.st = ST_PLAN;
                                end
                            end
                        end
                    endcase
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy          = (q.st != ST_IDLE);
    assign done          = q.done;
    assign bytes_written = q.written;
    assign verify_err    = q.verr;
    assign range_err     = q.rerr;
    assign spi_cs        = (q.st == ST_CMD) || (q.st == ST_DATA);

    assert_zero_len_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && length == '0) |=> (done && !range_err && !verify_err));

    assert_range_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        range_err |-> (!spi_cs && !poll_req));

    assert_stop_on_mismatch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(verify_err) |-> (done && !busy));

    assert_written_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bytes_written <= q.total);

    assert_in_ready_in_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (spi_cs && spi_tx_ready));

    assert_cs_off_while_polling_R10: assert property (@(posedge clk) disable iff (!rst_n)
        poll_req |-> !spi_cs);
endmodule

// File: tb/page_write_seq_bench.sv
module page_write_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PS    = 6;
    localparam int SHIFT = 8;
    localparam int NP    = 5;
    localparam int DEV   = PS * NP;
    localparam int LW    = $clog2(DEV + 1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 1'b0;
    logic [LW-1:0] start_addr = '0, length = '0;
    logic busy, done, verify_err, range_err, in_ready, spi_cs, spi_tx_valid, poll_req;
    logic [LW-1:0] bytes_written;
    logic in_valid = 1'b0;
    logic [7:0] in_data = 8'h00, spi_tx_data;
    logic spi_tx_ready = 1'b0, poll_done = 1'b0;
    logic [7:0] poll_status = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    page_write_seq #(.PAGE_SIZE(PS), .PAGE_SHIFT(SHIFT), .NUM_PAGES(NP)) u_page_write_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr), .length(length),
        .busy(busy), .done(done), .bytes_written(bytes_written), .verify_err(verify_err),
        .range_err(range_err), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .spi_cs(spi_cs), .spi_tx_valid(spi_tx_valid), .spi_tx_data(spi_tx_data),
        .spi_tx_ready(spi_tx_ready), .poll_req(poll_req), .poll_done(poll_done),
        .poll_status(poll_status)
    );

    int checks = 0, errors = 0;
    logic [7:0] exp_b [0:255];
    int exp_n, exp_frames, exp_written, fail_page;
    logic exp_verr;
    int ei, mism, mism_idx, frames, polls, ready_viol;
    logic [7:0] mism_act, mism_exp;
    logic cs_prev = 1'b0;
    int fi;
    logic [7:0] fb [0:3];
    logic pend_data = 1'b0;
    int di = 0, tick = 0, pc = 0, cyc_total = 0;

    function automatic logic [7:0] pay(int k);
        return 8'((k * 29 + 90) & 255);
    endfunction

    task automatic check(input bit ok, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", what, act, expv);
        end
    endtask

    task automatic push(input int v);
        exp_b[exp_n] = 8'(v);
        exp_n++;
    endtask

    task automatic build(input int s, input int len, input int fp);
        int page, ofs, left, k, ch, pa, a;
        exp_n = 0; exp_frames = 0; exp_written = 0; exp_verr = 1'b0;
        page = s / PS; ofs = s % PS; left = len; k = 0;
        while (left > 0) begin
            ch = (PS - ofs < left) ? PS - ofs : left;        // R3 chunk rule
            pa = page << SHIFT;
            if (ch < PS) begin                               // R4 preload
                push(8'h53); push(pa >> 16); push(pa >> 8); push(pa); exp_frames++;
            end
            a = pa + ofs;                                    // R5 program
            push(8'h82); push(a >> 16); push(a >> 8); push(a);
            for (int j = 0; j < ch; j++) push(pay(k + j));
            k += ch; exp_frames++;
            push(8'h60); push(pa >> 16); push(pa >> 8); push(pa); exp_frames++;  // R6
            if (page == fp) begin exp_verr = 1'b1; break; end
            exp_written += ch; left -= ch; page++; ofs = 0;
        end
    endtask

    // Sample side, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (in_ready && !spi_cs) ready_viol++;
            if (poll_req) polls++;
            if (spi_cs && !cs_prev) begin frames++; fi = 0; end
            if (spi_cs && spi_tx_valid && spi_tx_ready) begin
                if (fi < 4) fb[fi] = spi_tx_data;
                fi++;
                if (ei >= exp_n || spi_tx_data != exp_b[ei]) begin
                    if (mism == 0) begin
                        mism_idx = ei; mism_act = spi_tx_data;
                        mism_exp = (ei < exp_n) ? exp_b[ei] : 8'hxx;
                    end
                    mism++;
                end
                ei++;
            end
            cs_prev = spi_cs;
        end
        pend_data = in_valid && in_ready;
    end

    // Drive side: stream source, serial port and poller models
    always @(posedge clk) begin
        #1;
        tick++; cyc_total++;
        if (pend_data) di++;
        in_data      = pay(di);
        in_valid     = (tick % 4) != 1;
        spi_tx_ready = (tick % 3) != 2;
        if (poll_done) begin
            poll_done = 1'b0; pc = 0;
        end else if (poll_req) begin
            pc++;
            if (pc >= 3) begin
                poll_done   = 1'b1;
                poll_status = {1'b1, (fb[0] == 8'h60 && int'({fb[1], fb[2]}) == fail_page), 6'b101100};
            end
        end
        if (cyc_total > 190000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc_total, 190000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic run_op(input int s, input int len, input int fp, input bit reject);
        int cyc;
        fail_page = fp;
        if (!reject) build(s, len, fp);
        else begin exp_n = 0; exp_frames = 0; exp_written = 0; exp_verr = 1'b0; end
        @(negedge clk);
        ei = 0; mism = 0; frames = 0; polls = 0; ready_viol = 0; di = 0;
        start = 1'b1; start_addr = LW'(s); length = LW'(len);
        @(negedge clk);
        start = 1'b0; cyc = 1;
        while (!done && cyc < 3000) begin @(negedge clk); cyc++; end
        check(done, $sformatf("R8 done s=%0d l=%0d", s, len), cyc, 0);
        if (len == 0) check(cyc == 1, "R1 one-cycle completion", cyc, 1);
        if (reject) begin
            check(cyc == 1, "R2 one-cycle reject", cyc, 1);
            check(range_err == 1'b1, "R2 range_err", range_err, 1);
            check(frames == 0 && polls == 0, "R2 no bus activity", frames + polls, 0);
        end else begin
            check(range_err == 1'b0, "R2 range_err low", range_err, 0);
        end
        check(int'(bytes_written) == exp_written, $sformatf("R8 bytes_written s=%0d l=%0d", s, len),
              bytes_written, exp_written);
        check(verify_err == exp_verr, $sformatf("R7 verify_err s=%0d l=%0d", s, len),
              verify_err, exp_verr);
        check(mism == 0, $sformatf("R5 stream byte %0d s=%0d l=%0d", mism_idx, s, len),
              mism_act, mism_exp);
        check(ei == exp_n, $sformatf("R3 bytes sent s=%0d l=%0d", s, len), ei, exp_n);
        check(frames == exp_frames, $sformatf("R10 frame count s=%0d l=%0d", s, len),
              frames, exp_frames);
        check(ready_viol == 0, "R9 in_ready outside frame", ready_viol, 0);
    endtask

    initial begin
        fb[0] = 8'h00; fb[1] = 8'h00; fb[2] = 8'h00; fb[3] = 8'h00;
        ei = 0; mism = 0; frames = 0; polls = 0; ready_viol = 0; fi = 0;
        exp_n = 0; fail_page = -1;
        repeat (3) @(negedge clk);
        check(!busy && !done && !spi_cs && !poll_req && bytes_written == '0,
              "R8 reset state", busy, 0);
        check(!in_ready, "R9 in_ready low in reset", in_ready, 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_op(5, 0, -1, 1'b0);           // R1
        run_op(29, 0, -1, 1'b0);          // R1
        run_op(25, 6, -1, 1'b1);          // R2 one past end
        run_op(0, 31, -1, 1'b1);          // R2
        run_op(29, 2, -1, 1'b1);          // R2
        for (int s = 0; s < DEV; s++)
            for (int l = 1; l <= DEV - s; l++)
                run_op(s, l, -1, 1'b0);   // R3 R4 R5 R6 R8 sweep
        run_op(2, 20, 1, 1'b0);           // R7 middle page
        run_op(0, 6, 0, 1'b0);            // R7 first page
        run_op(13, 17, 4, 1'b0);          // R7 last page
        run_op(0, 30, -1, 1'b0);          // recovery after mismatch
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule